// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is the only master on a two-wire I2C bus and runs one transaction per command. The host sets a 7-bit target address, a read/write flag and a data byte count, then pulses a start request. The block issues a start condition and sends the address byte. It then either sends the requested number of bytes taken from the host or collects that many bytes from the target. It closes the transaction with a stop condition and pulses a completion flag.

Both bus lines are open-drain. The block never drives a line high. It only asserts an output-enable that pulls the line low, and it reads the data line back through an input pin. The bus clock is derived from the system clock. Each bus clock period has four equal quarters of `QTR_CYC` system cycles. With the default of 125 quarters at a 50 MHz system clock, the bus runs at 100 kHz. The block does not support arbitration, clock stretching or 10-bit addresses.

Top module: `iic_xfer_master`

## Requirements
- R1: After reset and whenever no transaction is active, both output-enables are low (lines released), and `busy`, `done`, `rd_valid` and `wr_take` are low.
- R2: A transaction begins with a start condition: SDA is pulled low while SCL is released, and SCL is pulled low only after that.
- R3: The first byte on the bus is `{cmd_addr, cmd_rd}`, with the read/write flag in bit 0 (0 = write, 1 = read), sent most significant bit first. Outside start and stop, SDA changes only while SCL is held low.
- R4: Every SCL period within a byte lasts 4*`QTR_CYC` system clocks, and the master changes SDA exactly `QTR_CYC` clocks after SCL falls.
- R5: In a write, the master sends `cmd_len` data bytes, most significant bit first. Each byte is taken from `wr_byte` in the cycle where `wr_take` pulses, and the first one is taken at the end of the address acknowledge.
- R6: The master releases SDA on the ninth clock of every byte it sends and samples the acknowledge there. A high acknowledge sets `nack` and is followed at once by a stop, and the remaining bytes are not sent.
- R7: In a read, the master keeps SDA released for the eight data bits, assembles the byte MSB first and presents it on `rd_byte` with a one-clock `rd_valid` pulse.
- R8: In a read, the master answers every byte except the last with a low acknowledge and answers the last byte with a high (released) acknowledge before the stop.
- R9: A transaction ends with a stop condition: SDA rises while SCL is released. `done` pulses for exactly one clock after the stop, in the same cycle where `busy` falls.
- R10: `nack` is cleared when a start request is accepted and otherwise holds its value until the next accepted request.
- R11: A start request made while `busy` is high is ignored: no additional transaction follows.
- R12: A `cmd_len` of zero produces an address-only transaction: start, address byte with acknowledge, then stop, with no `wr_take` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_go | input | 1 | Start request, accepted when idle |
| cmd_addr | input | 7 | Target address |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_len | input | LEN_W | Number of data bytes after the address |
| wr_byte | input | 8 | Next byte to send in a write |
| wr_take | output | 1 | One-clock pulse when `wr_byte` is captured |
| rd_byte | output | 8 | Last byte received |
| rd_valid | output | 1 | One-clock pulse when `rd_byte` is updated |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse after the stop condition |
| nack | output | 1 | Target returned a high acknowledge in the last transaction |
| sda_in | input | 1 | Data line as seen on the bus |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The bench targets an address that is refused, and a data byte refused partway through a write. A design that ignored the high acknowledge would keep clocking bytes out and would show extra bus bytes and `wr_take` pulses. In reads the bench checks that only the last byte is answered high; a design off by one there either leaves the target driving SDA into the stop or cuts the read short. It also covers a zero-length transfer, a start request made mid-transaction, and the exact quarter-period spacing of SDA changes. Each of these would surface as an unexpected bus event, a wrong byte count, or a mistimed SDA edge.

// File: rtl/iic_pkg.sv
package iic_pkg;

  // Transaction phases of the master
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } iic_state_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned SLOT_CNT_W = 4;   // counts bits 0..7 plus the ack slot
  localparam logic [SLOT_CNT_W-1:0] ACK_SLOT = 4'd8;
  localparam logic [SLOT_CNT_W-1:0] LAST_DATA_SLOT = 4'd7;

endpackage

// File: rtl/iic_qtr_timer.sv
// Produces a one-clock tick at the end of every quarter of the SCL period.
module iic_qtr_timer #(
  parameter int unsigned QTR_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/iic_shift_unit.sv
// Byte shifter shared by transmit and receive: loads in parallel, shifts left
// taking the sampled line value into bit 0.
module iic_shift_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         msb
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      sh_d = {sh_q[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign data = sh_q;
  assign msb  = sh_q[W-1];

endmodule

// File: rtl/iic_xfer_master.sv
module iic_xfer_master
  import iic_pkg::*;
#(
  parameter int unsigned QTR_CYC = 125,
  parameter int unsigned LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic [6:0]       cmd_addr,
  input  logic             cmd_rd,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [7:0]       wr_byte,
  output logic             wr_take,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             nack,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);

  // ---------------- reset release and input synchroniser ----------------
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe[1];

  logic sda_meta, sda_s;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sda_meta <= 1'b1;
      sda_s    <= 1'b1;
    end else begin
      sda_meta <= sda_in;
      sda_s    <= sda_meta;
    end
  end

  // ---------------- state ----------------
  iic_state_e            st_q, st_d;
  logic [1:0]            qtr_q, qtr_d;
  logic [SLOT_CNT_W-1:0] slot_q, slot_d;
  logic [LEN_W-1:0]      rem_q, rem_d;
  logic                  addr_ph_q, addr_ph_d;
  logic                  rd_q, rd_d;
  logic                  nack_q, nack_d;
  logic                  ack_q, ack_d;
  logic                  scl_low_q, scl_low_d;
  logic                  sda_low_q, sda_low_d;
  logic [7:0]            rdb_q, rdb_d;
  logic                  rdv_q, rdv_d;
  logic                  take_q, take_d;
  logic                  done_q, done_d;

  // ---------------- submodules ----------------
  logic       tick;
  logic       sh_load, sh_shift, sh_msb;
  logic [7:0] sh_val, sh_data;

  iic_qtr_timer #(.QTR_CYC(QTR_CYC)) u_timer (
    .clk   (clk),
    .rst_n (srst_n),
    .run   (st_q != ST_IDLE),
    .tick  (tick)
  );

  iic_shift_unit #(.W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (sh_load),
    .load_val (sh_val),
    .shift    (sh_shift),
    .bit_in   (sda_s),
    .data     (sh_data),
    .msb      (sh_msb)
  );

  // the master owns SDA for the address byte and for every write byte
  logic talk;
  assign talk = addr_ph_q || !rd_q;

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d      = st_q;
    qtr_d     = qtr_q;
    slot_d    = slot_q;
    rem_d     = rem_q;
    addr_ph_d = addr_ph_q;
    rd_d      = rd_q;
    nack_d    = nack_q;
    ack_d     = ack_q;
    scl_low_d = scl_low_q;
    sda_low_d = sda_low_q;
    rdb_d     = rdb_q;
    rdv_d     = 1'b0;
    take_d    = 1'b0;
    done_d    = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    sh_val    = wr_byte;

    if (st_q == ST_IDLE) begin
      scl_low_d = 1'b0;
      sda_low_d = 1'b0;
      if (cmd_go) begin
        st_d      = ST_START;
        qtr_d     = 2'd0;
        slot_d    = '0;
        rem_d     = cmd_len;
        addr_ph_d = 1'b1;
        rd_d      = cmd_rd;
        nack_d    = 1'b0;
        sh_load   = 1'b1;
        sh_val    = {cmd_addr, cmd_rd};
      end
    end else if (tick) begin
      qtr_d = qtr_q + 2'd1;
      unique case (st_q)
        ST_START: begin
          if (qtr_q == 2'd1) sda_low_d = 1'b1;
          if (qtr_q == 2'd3) begin
            st_d      = ST_BITS;
            slot_d    = '0;
            scl_low_d = 1'b1;
          end
        end
        ST_BITS: begin
          unique case (qtr_q)
            2'd0: begin
              if (slot_q == ACK_SLOT) begin
                sda_low_d = talk ? 1'b0 : (rem_q != '0);
              end else begin
                sda_low_d = talk ? ~sh_msb : 1'b0;
              end
            end
            2'd1: scl_low_d = 1'b0;
            2'd2: begin
              if (slot_q == ACK_SLOT) ack_d = sda_s;
              else                    sh_shift = 1'b1;
            end
            default: begin
              scl_low_d = 1'b1;
              if (slot_q != ACK_SLOT) begin
                slot_d = slot_q + SLOT_CNT_W'(1);
                if (slot_q == LAST_DATA_SLOT && !talk) begin
                  rdb_d = sh_data;
                  rdv_d = 1'b1;
                end
              end else if (talk && ack_q) begin
                nack_d = 1'b1;
                st_d   = ST_STOP;
              end else if (rem_q == '0) begin
                st_d = ST_STOP;
              end else begin
                rem_d     = rem_q - LEN_W'(1);
                slot_d    = '0;
                addr_ph_d = 1'b0;
                if (!rd_q) begin
                  sh_load = 1'b1;
                  take_d  = 1'b1;
                end
              end
            end
          endcase
        end
        ST_STOP: begin
          unique case (qtr_q)
            2'd0:    sda_low_d = 1'b1;
            2'd1:    scl_low_d = 1'b0;
            2'd2:    sda_low_d = 1'b0;
            default: begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          endcase
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q      <= ST_IDLE;
      qtr_q     <= 2'd0;
      slot_q    <= '0;
      rem_q     <= '0;
      addr_ph_q <= 1'b0;
      rd_q      <= 1'b0;
      nack_q    <= 1'b0;
      ack_q     <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      rdb_q     <= '0;
      rdv_q     <= 1'b0;
      take_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      qtr_q     <= qtr_d;
      slot_q    <= slot_d;
      rem_q     <= rem_d;
      addr_ph_q <= addr_ph_d;
      rd_q      <= rd_d;
      nack_q    <= nack_d;
      ack_q     <= ack_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
      rdb_q     <= rdb_d;
      rdv_q     <= rdv_d;
      take_q    <= take_d;
      done_q    <= done_d;
    end
  end

  assign scl_oe   = scl_low_q;
  assign sda_oe   = sda_low_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign nack     = nack_q;
  assign rd_byte  = rdb_q;
  assign rd_valid = rdv_q;
  assign wr_take  = take_q;

endmodule

// File: rtl/iic_xfer_checker.sv
module iic_xfer_checker
  import iic_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input iic_state_e st,
  input logic       busy,
  input logic       done,
  input logic       nack,
  input logic       cmd_go,
  input logic       rd_valid,
  input logic       wr_take,
  input logic       scl_oe,
  input logic       sda_oe
);

  // R1: lines released whenever idle
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R2: a transaction starts with both lines released
  p_start_from_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!scl_oe && !sda_oe));

  // R3: SDA moves under a released SCL only for start or stop
  p_sda_hi_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == ST_START || st == ST_STOP));

  // R9: done is a single pulse that coincides with idle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: nack holds unless a new request arrives
  p_nack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nack && !cmd_go) |=> nack);

  // R7: read strobes only inside a transaction
  p_rdv_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  // R5: host-side strobes never overlap
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, rd_valid, wr_take}));

endmodule

bind iic_xfer_master iic_xfer_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .st       (st_q),
  .busy     (busy),
  .done     (done),
  .nack     (nack),
  .cmd_go   (cmd_go),
  .rd_valid (rd_valid),
  .wr_take  (wr_take),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe)
);

// File: tb/sim_iic_xfer_master.sv
module sim_iic_xfer_master;

  localparam int QTR   = 4;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             cmd_go;
  logic [6:0]       cmd_addr;
  logic             cmd_rd;
  logic [LEN_W-1:0] cmd_len;
  logic [7:0]       wr_byte;
  logic             wr_take;
  logic [7:0]       rd_byte;
  logic             rd_valid;
  logic             busy, done, nack;
  logic             sda_in, scl_oe, sda_oe;

  logic slv_low;
  logic scl_bus, sda_bus;
  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | slv_low);
  assign sda_in  = sda_bus;

  iic_xfer_master #(.QTR_CYC(QTR), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_addr(cmd_addr),
    .cmd_rd(cmd_rd), .cmd_len(cmd_len), .wr_byte(wr_byte), .wr_take(wr_take),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .busy(busy), .done(done),
    .nack(nack), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // ---------------- scoreboard ----------------
  typedef struct {
    int        kind;   // 0 start, 1 byte, 2 stop
    logic [7:0] val;
    logic      ack;
    string     tag;
  } ev_t;

  ev_t        expq[$];
  logic [7:0] rdq[$];
  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] tx_dat [8];
  logic [7:0] rd_dat [8];
  logic       ack_plan [9];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_ev(input int k, input logic [7:0] v, input logic a, input string t);
    ev_t e;
    e.kind = k; e.val = v; e.ack = a; e.tag = t;
    expq.push_back(e);
  endtask

  task automatic expect_ev(input int k, input logic [7:0] v, input logic a);
    ev_t e;
    if (expq.size() == 0) begin
      chk(1'b0, "R3 unexpected bus event", k * 512 + v * 2 + a, -1);
    end else begin
      e = expq.pop_front();
      chk((e.kind == k) && (k != 1 || (e.val == v && e.ack == a)), e.tag,
          k * 512 + v * 2 + a, e.kind * 512 + e.val * 2 + e.ack);
    end
  endtask

  // ---------------- write-data host ----------------
  int wr_idx = 0;
  int take_cnt = 0;
  assign wr_byte = tx_dat[wr_idx[2:0]];
  always @(negedge clk) begin
    if (cmd_go && !busy) begin
      wr_idx   <= 0;
      take_cnt <= 0;
    end else if (wr_take) begin
      wr_idx   <= wr_idx + 1;
      take_cnt <= take_cnt + 1;
    end
  end

  // ---------------- bus monitor and target model ----------------
  int cyc = 0;
  logic prev_scl, prev_sda, prev_sda_oe, prev_scl_oe;
  int bc, bidx, last_rise, last_fall;
  logic [7:0] sh;
  logic rdm, last_ack;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_scl = 1'b1; prev_sda = 1'b1; prev_sda_oe = 1'b0; prev_scl_oe = 1'b0;
      bc = 0; bidx = 0; sh = '0; rdm = 1'b0; last_ack = 1'b1;
      last_rise = 0; last_fall = 0;
      slv_low = 1'b0;
    end else begin
      if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
        expect_ev(0, 8'h00, 1'b0);
        bc = 0; bidx = 0; slv_low = 1'b0;
      end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
        expect_ev(2, 8'h00, 1'b0);
        slv_low = 1'b0;
      end else if (!prev_scl && scl_bus) begin
        if (bc >= 1) chk(cyc - last_rise == 4 * QTR, "R4 SCL period", cyc - last_rise, 4 * QTR);
        last_rise = cyc;
        if (bc < 8) begin
          sh = {sh[6:0], sda_bus};
          bc++;
        end else begin
          expect_ev(1, sh, sda_bus);
          if (bidx == 0) rdm = sh[0];
          last_ack = sda_bus;
          bidx++;
          bc = 0;
        end
      end else if (prev_scl && !scl_bus) begin
        last_fall = cyc;
        if (bc == 8) begin
          slv_low = (bidx == 0 || !rdm) ? !ack_plan[bidx] : 1'b0;
        end else if (bc == 0) begin
          slv_low = (bidx >= 1 && rdm && !last_ack) ? !rd_dat[bidx-1][7] : 1'b0;
        end else begin
          slv_low = (bidx >= 1 && rdm) ? !rd_dat[bidx-1][7-bc] : 1'b0;
        end
      end
      if (scl_oe && prev_scl_oe && (sda_oe != prev_sda_oe))
        chk(cyc - last_fall == QTR, "R4 SDA update point", cyc - last_fall, QTR);
      if (rd_valid) begin
        if (rdq.size() == 0) chk(1'b0, "R7 unexpected rd_valid", rd_byte, -1);
        else begin
          logic [7:0] exp_b;
          exp_b = rdq.pop_front();
          chk(rd_byte == exp_b, "R7 read byte value", rd_byte, exp_b);
        end
      end
      prev_scl = scl_bus; prev_sda = sda_bus;
      prev_sda_oe = sda_oe; prev_scl_oe = scl_oe;
    end
  end

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- driver ----------------
  task automatic run_txn(input logic [6:0] a, input bit rd, input int len, input bit poke_go);
    bit   exp_nack = 1'b0;
    int   exp_take = 0;
    int   w = 0;
    push_ev(0, 8'h00, 1'b0, "R2 start condition");
    push_ev(1, {a, rd}, ack_plan[0], "R3 address byte");
    if (ack_plan[0]) exp_nack = 1'b1;
    else begin
      for (int i = 0; i < len; i++) begin
        if (rd) begin
          push_ev(1, rd_dat[i], (i == len - 1), "R8 read byte and ack");
          rdq.push_back(rd_dat[i]);
        end else begin
          push_ev(1, tx_dat[i], ack_plan[i+1], "R5 write byte");
          exp_take++;
          if (ack_plan[i+1]) begin exp_nack = 1'b1; break; end
        end
      end
    end
    push_ev(2, 8'h00, 1'b0, exp_nack ? "R6 stop after refusal" : "R9 stop condition");

    @(posedge clk); #1;
    cmd_addr = a; cmd_rd = rd; cmd_len = LEN_W'(len); cmd_go = 1'b1;
    @(posedge clk); #1;
    cmd_go = 1'b0;
    @(negedge clk);
    chk(nack == 1'b0, "R10 nack cleared by request", nack, 0);
    chk(busy == 1'b1, "R2 busy after request", busy, 1);
    if (poke_go) begin
      repeat (150) @(posedge clk);
      #1; cmd_addr = 7'h0F; cmd_rd = 1'b1; cmd_go = 1'b1;
      @(posedge clk); #1; cmd_go = 1'b0; cmd_addr = a; cmd_rd = rd;
    end
    do begin @(negedge clk); w++; end while (!done && w < 20000);
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(busy == 1'b0, "R9 busy falls with done", busy, 0);
    chk(nack == exp_nack, "R6 nack flag", nack, exp_nack);
    chk(expq.size() == 0, "R9 all bus events seen", expq.size(), 0);
    chk(rdq.size() == 0, "R7 all read bytes delivered", rdq.size(), 0);
    chk(take_cnt == exp_take, "R5 wr_take count", take_cnt, exp_take);
    @(negedge clk);
    chk(done == 1'b0, "R9 done lasts one clock", done, 0);
    if (poke_go) begin
      repeat (100) @(negedge clk);
      chk(busy == 1'b0, "R11 request during busy ignored", busy, 0);
    end
    if (len == 0) chk(take_cnt == 0, "R12 no byte taken", take_cnt, 0);
  endtask

  task automatic clear_plan();
    for (int i = 0; i < 9; i++) ack_plan[i] = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cmd_go = 1'b0; cmd_addr = '0; cmd_rd = 1'b0; cmd_len = '0;
    for (int i = 0; i < 8; i++) begin tx_dat[i] = '0; rd_dat[i] = '0; end
    clear_plan();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle flags after reset", {busy, done}, 0);
    chk(rd_valid == 1'b0 && wr_take == 1'b0, "R1 strobes low after reset", {rd_valid, wr_take}, 0);

    // write two bytes, all accepted
    clear_plan(); tx_dat[0] = 8'hA5; tx_dat[1] = 8'h3C;
    run_txn(7'h50, 1'b0, 2, 1'b0);

    // read three bytes
    clear_plan(); rd_dat[0] = 8'hC3; rd_dat[1] = 8'h01; rd_dat[2] = 8'h80;
    run_txn(7'h2B, 1'b1, 3, 1'b0);

    // address refused
    clear_plan(); ack_plan[0] = 1'b1; tx_dat[0] = 8'h11;
    run_txn(7'h11, 1'b0, 3, 1'b0);
    repeat (50) @(negedge clk);
    chk(nack == 1'b1, "R10 nack held while idle", nack, 1);
    chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released when idle", {scl_oe, sda_oe}, 0);

    // second data byte refused
    clear_plan(); ack_plan[2] = 1'b1;
    tx_dat[0] = 8'h5A; tx_dat[1] = 8'hFF; tx_dat[2] = 8'h00;
    run_txn(7'h7F, 1'b0, 3, 1'b0);

    // address-only transfer
    clear_plan();
    run_txn(7'h40, 1'b0, 0, 1'b0);

    // single-byte read
    clear_plan(); rd_dat[0] = 8'h96;
    run_txn(7'h01, 1'b1, 1, 1'b0);

    // request while busy
    clear_plan(); tx_dat[0] = 8'h81; tx_dat[1] = 8'h7E;
    run_txn(7'h33, 1'b0, 2, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule